// File: doc/BRIEF.md
# Register Write Sequencer for a Two-Wire Bus

This block is a two-wire (I2C) bus master. It performs exactly one register write to a video decoder slave each time it is started. A request supplies an 8-bit register subaddress and an 8-bit value. The block then sends the whole frame on open-drain SCL and SDA lines. It pulls a line low by asserting that line's output enable, and it reads back the real line levels through two synchronizers.

The slave needs settling time after a write to its lower register range. For such a write, after the data byte has been acknowledged, the block keeps SCL low for a fixed number of system clock cycles before it sends STOP. That count comes from the clock frequency and wait time parameters, so longer waits are a parameter change. Writes to the upper range go straight to STOP.

A per-request enable turns on clock-stretch checking. With it set, every SCL high phase is held until the sampled line really reads high. The fixed wait is then dropped, and the slave pacing the STOP by holding SCL low takes its place. If the slave does not acknowledge a byte, the block flags NACK, drops the rest of the frame and any wait, and sends STOP.

Top module: `regwr_i2c_master`

## Requirements
- R1: After reset, and whenever the block is idle, scl_oe and sda_oe are both 0 (lines released), and busy and done are 0. nack is also 0 after reset.
- R2: An accepted request produces this frame on the lines: START, the device byte B8h, the subaddress byte, the data byte, then STOP. Each byte is sent MSB first and is followed by a ninth clock, during which SDA is released so the slave can acknowledge (ACK = SDA low).
- R3: Within a frame, SDA changes only while SCL is low. The exceptions are the START edge (SDA falls with SCL high) and the STOP edge (SDA rises with SCL high). Each frame therefore shows exactly one START and one STOP.
- R4: For subaddresses 00h to 8Fh with stretch checking off, the block holds SCL low for at least CLK_MHZ*WAIT_US cycles between the SCL fall that ends the data ACK clock and the SCL rise of STOP. The wait state itself lasts exactly CLK_MHZ*WAIT_US cycles.
- R5: For subaddresses 90h to FFh, no wait is inserted, and STOP begins two SCL quarter periods after the data ACK clock ends.
- R6: With stretch_en captured as 1, bus timing works as follows:
  - The SCL high phase does not advance while the synchronized SCL reads low.
  - No fixed wait is inserted for any subaddress.
  - The STOP's SCL rise waits for the slave to release SCL.
- R7: If any ACK clock samples SDA high, the block does the following:
  - It sets nack.
  - It sends no further byte and inserts no wait.
  - It ends the frame with STOP.
- R8: busy rises on the cycle after a request is accepted and stays high until STOP completes. done is a one-cycle pulse on the cycle busy falls. nack keeps its value until the next request is accepted.
- R9: A request raised while busy is ignored: the frame in progress carries the original bytes, and no second frame follows.
- R10: With stretch checking off, each SCL high phase of a bit lasts 2*Q cycles, where Q = CLK_MHZ*1000/(4*SCL_KHZ).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a write; taken only when idle |
| reg_addr | input | 8 | Register subaddress to write |
| reg_data | input | 8 | Value to write |
| stretch_en | input | 1 | Enables clock-stretch checking for this request |
| busy | output | 1 | High while a frame is in progress |
| done | output | 1 | One-cycle pulse when STOP completes |
| nack | output | 1 | Set when the last frame saw an ACK sample high |
| scl_in | input | 1 | Sampled SCL line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_in | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The in-design assertions check these rules on every cycle:
- SDA moves only while SCL is low, outside the START and STOP edges.
- The wait state lasts exactly the derived cycle count.
- The wait state is never entered for an upper-range address, with stretching on, or after a NACK.
- A stretch stall freezes the bit sequencer.
- The idle lines are released.
- A request seen while busy leaves the captured bytes untouched.

The directed scenarios use a small slave model to show what only the whole frame reveals:
- the decoded byte order and values;
- the measured SCL low gap before STOP at the 8Fh/90h boundary;
- the NACK cut-off at different bytes;
- the STOP being held off by a slave that keeps SCL low.

// File: rtl/regwr_pkg.sv
package regwr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_BITS,
      ST_WAIT,
      ST_STOP
   } seq_state_t;

   // bytes in one write frame: device, subaddress, data
   localparam int unsigned FRAME_BYTES = 3;
   // bit slot index carrying the acknowledge
   localparam int unsigned ACK_SLOT = 8;

   function automatic logic needs_settle(input logic [7:0] sub, input logic [7:0] last_low);
      return sub <= last_low;
   endfunction

endpackage

// File: rtl/regwr_line_sync.sv
module regwr_line_sync #(
   parameter int unsigned STAGES = 2,
   parameter logic        IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES > 4) begin : g_bad_stages
         $error("regwr_line_sync: STAGES must be 0 to 4");
      end

      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_ff
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= {STAGES{IDLE_LEVEL}};
            end else begin
               chain[0] <= d;
               for (int i = 1; i < STAGES; i++) begin
                  chain[i] <= chain[i-1];
               end
            end
         end
         assign q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/regwr_qtick.sv
module regwr_qtick #(
   parameter int unsigned QTR = 67
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic stall,
   output logic tick
);

   localparam int unsigned CW = (QTR > 1) ? $clog2(QTR) : 1;
   localparam logic [CW-1:0] LAST = CW'(QTR - 1);

   generate
      if (QTR < 2) begin : g_bad_qtr
         $error("regwr_qtick: quarter period must be at least 2 cycles");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!en) begin
         cnt <= '0;
      end else if (!stall) begin
         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end

   assign tick = en && !stall && (cnt == LAST);

endmodule

// File: rtl/regwr_hold_timer.sv
module regwr_hold_timer #(
   parameter int unsigned LIMIT = 1728
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);

   localparam int unsigned TW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("regwr_hold_timer: LIMIT must be at least 1");
      end
   endgenerate

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign expired = run && (cnt == TW'(LIMIT - 1));

endmodule

// File: rtl/regwr_i2c_master.sv
module regwr_i2c_master
   import regwr_pkg::*;
#(
   parameter int unsigned CLK_MHZ     = 27,
   parameter int unsigned SCL_KHZ     = 100,
   parameter int unsigned WAIT_US     = 64,
   parameter logic [7:0]  DEV_ADDR    = 8'hB8,
   parameter logic [7:0]  LOW_LAST    = 8'h8F,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  logic [7:0] reg_addr,
   input  logic [7:0] reg_data,
   input  logic       stretch_en,
   output logic       busy,
   output logic       done,
   output logic       nack,
   input  logic       scl_in,
   output logic       scl_oe,
   input  logic       sda_in,
   output logic       sda_oe
);

   localparam int unsigned QTR_CYC  = (CLK_MHZ * 1000) / (4 * SCL_KHZ);
   localparam int unsigned WAIT_CYC = CLK_MHZ * WAIT_US;
   localparam logic [1:0]  LAST_BYTE = 2'(FRAME_BYTES - 1);
   localparam logic [3:0]  ACK_IDX   = 4'(ACK_SLOT);

   generate
      if (CLK_MHZ == 0 || SCL_KHZ == 0) begin : g_bad_rate
         $error("regwr_i2c_master: clock and bus rates must be non-zero");
      end
      if (QTR_CYC < 2) begin : g_bad_div
         $error("regwr_i2c_master: SCL too fast for the system clock");
      end
      if (WAIT_US == 0) begin : g_bad_wait
         $error("regwr_i2c_master: settle wait must be non-zero");
      end
      if (DEV_ADDR[0] != 1'b0) begin : g_bad_dev
         $error("regwr_i2c_master: device byte must carry the write direction");
      end
   endgenerate

   seq_state_t state;
   logic [1:0] phase;
   logic [3:0] bit_idx;
   logic [1:0] byte_idx;
   logic [7:0] tx_sh;
   logic [7:0] addr_q;
   logic [7:0] data_q;
   logic       stretch_q;
   logic       scl_s;
   logic       sda_s;
   logic       tick;
   logic       stall;
   logic       settle_done;

   assign busy = (state != ST_IDLE);

   regwr_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s)
   );

   regwr_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
   );

   // a released SCL that still reads low means the slave is stretching
   assign stall = busy && stretch_q && !scl_oe && !scl_s;

   regwr_qtick #(.QTR(QTR_CYC)) u_qtick (
      .clk(clk), .rst_n(rst_n),
      .en(busy && (state != ST_WAIT)),
      .stall(stall),
      .tick(tick)
   );

   regwr_hold_timer #(.LIMIT(WAIT_CYC)) u_settle (
      .clk(clk), .rst_n(rst_n),
      .run(state == ST_WAIT),
      .expired(settle_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         phase     <= '0;
         bit_idx   <= '0;
         byte_idx  <= '0;
         tx_sh     <= '0;
         addr_q    <= '0;
         data_q    <= '0;
         stretch_q <= 1'b0;
         scl_oe    <= 1'b0;
         sda_oe    <= 1'b0;
         done      <= 1'b0;
         nack      <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req) begin
                  addr_q    <= reg_addr;
                  data_q    <= reg_data;
                  stretch_q <= stretch_en;
                  nack      <= 1'b0;
                  phase     <= '0;
                  state     <= ST_START;
               end
            end
            ST_START: begin
               if (tick) begin
                  phase <= phase + 2'd1;
                  unique case (phase)
                     2'd0: sda_oe <= 1'b1;
                     2'd1: scl_oe <= 1'b1;
                     2'd2: ;
                     2'd3: begin
                        state    <= ST_BITS;
                        bit_idx  <= '0;
                        byte_idx <= '0;
                        tx_sh    <= DEV_ADDR;
                     end
                  endcase
               end
            end
            ST_BITS: begin
               if (tick) begin
                  phase <= phase + 2'd1;
                  unique case (phase)
                     2'd0: sda_oe <= (bit_idx == ACK_IDX) ? 1'b0 : ~tx_sh[7];
                     2'd1: scl_oe <= 1'b0;
                     2'd2: ;
                     2'd3: begin
                        scl_oe <= 1'b1;
                        if (bit_idx != ACK_IDX) begin
                           bit_idx <= bit_idx + 4'd1;
                           tx_sh   <= {tx_sh[6:0], 1'b0};
                        end else if (sda_s) begin
                           nack  <= 1'b1;
                           state <= ST_STOP;
                        end else if (byte_idx == LAST_BYTE) begin
                           state <= (!stretch_q && needs_settle(addr_q, LOW_LAST)) ? ST_WAIT : ST_STOP;
                        end else begin
                           byte_idx <= byte_idx + 2'd1;
                           bit_idx  <= '0;
                           tx_sh    <= (byte_idx == 2'd0) ? addr_q : data_q;
                        end
                     end
                  endcase
               end
            end
            ST_WAIT: begin
               if (settle_done) begin
                  state <= ST_STOP;
                  phase <= '0;
               end
            end
            ST_STOP: begin
               if (tick) begin
                  phase <= phase + 2'd1;
                  unique case (phase)
                     2'd0: sda_oe <= 1'b1;
                     2'd1: scl_oe <= 1'b0;
                     2'd2: sda_oe <= 1'b0;
                     2'd3: begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                     end
                  endcase
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // independent count of cycles spent in the settle state
   logic [31:0] chk_wait_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chk_wait_cnt <= '0;
      else        chk_wait_cnt <= (state == ST_WAIT) ? chk_wait_cnt + 32'd1 : 32'd0;
   end

   assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_oe && !sda_oe));

   assert_sda_moves_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe) && state != ST_START && state != ST_STOP) |-> (scl_oe && $past(scl_oe)));

   assert_settle_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_WAIT && state != ST_WAIT) |-> (chk_wait_cnt == WAIT_CYC));

   assert_settle_low_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) |-> (addr_q <= LOW_LAST && !stretch_q && scl_oe));

   assert_stall_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && state != ST_IDLE) |=> ($stable(phase) && $stable(state)));

   assert_nack_no_settle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) |-> !nack);

   assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   assert_busy_ignores_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req) |=> ($stable(addr_q) && $stable(data_q)));

endmodule

// File: tb/tb_regwr_i2c_master.sv
`timescale 1ns/1ps
module tb_regwr_i2c_master;

   localparam int unsigned T_MHZ  = 8;
   localparam int unsigned T_KHZ  = 500;
   localparam int unsigned T_WUS  = 4;
   localparam int Q_TB    = (T_MHZ * 1000) / (4 * T_KHZ);   // 4
   localparam int WAIT_TB = T_MHZ * T_WUS;                  // 32

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0;
   logic [7:0] reg_addr = '0;
   logic [7:0] reg_data = '0;
   logic stretch_en = 1'b0;
   logic busy, done, nack, scl_oe, sda_oe;
   logic slv_scl_hold = 1'b0;
   logic slv_sda_low = 1'b0;
   logic scl_line, sda_line;

   assign scl_line = ~(scl_oe | slv_scl_hold);
   assign sda_line = ~(sda_oe | slv_sda_low);

   always #2 clk = ~clk;

   regwr_i2c_master #(.CLK_MHZ(T_MHZ), .SCL_KHZ(T_KHZ), .WAIT_US(T_WUS)) dut (
      .clk(clk), .rst_n(rst_n), .req(req), .reg_addr(reg_addr), .reg_data(reg_data),
      .stretch_en(stretch_en), .busy(busy), .done(done), .nack(nack),
      .scl_in(scl_line), .scl_oe(scl_oe), .sda_in(sda_line), .sda_oe(sda_oe)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // slave model configuration (written only by the stimulus process)
   int cfg_nack = -1;
   int cfg_hold = 0;

   // slave model state (written only by the slave process)
   logic [7:0] rx [0:3];
   int nbytes = 0, bitn = 0, start_cnt = 0, stop_cnt = 0;
   int t_fall = -1, t_rise = -1, rise_t = 0, high_len = 0, hold_left = 0;
   logic in_ack = 1'b0, p_scl = 1'b1, p_sda = 1'b1;
   logic [7:0] shreg = '0;

   always @(negedge clk) begin
      if (p_scl && scl_line && p_sda && !sda_line) begin
         start_cnt = start_cnt + 1;
         bitn = 0; nbytes = 0; in_ack = 1'b0; t_fall = -1; t_rise = -1;
      end
      if (p_scl && scl_line && !p_sda && sda_line) stop_cnt = stop_cnt + 1;
      if (!p_scl && scl_line) begin
         if (bitn < 8) begin
            shreg = {shreg[6:0], sda_line};
            bitn = bitn + 1;
         end
         if (t_fall >= 0 && t_rise < 0) t_rise = cyc;
         rise_t = cyc;
      end
      if (p_scl && !scl_line) begin
         high_len = cyc - rise_t;
         if (in_ack) begin
            in_ack = 1'b0;
            slv_sda_low = 1'b0;
            bitn = 0;
            if (nbytes == 3) begin
               t_fall = cyc;
               hold_left = cfg_hold;
            end
         end else if (bitn == 8 && nbytes < 4) begin
            rx[nbytes] = shreg;
            slv_sda_low = (nbytes != cfg_nack);
            nbytes = nbytes + 1;
            in_ack = 1'b1;
         end
      end
      if (hold_left > 0) begin
         slv_scl_hold = 1'b1;
         hold_left = hold_left - 1;
      end else begin
         slv_scl_hold = 1'b0;
      end
      p_scl = scl_line;
      p_sda = sda_line;
   end

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // issues one write and waits for the done pulse; returns start/stop deltas
   task automatic run_write(input logic [7:0] a, input logic [7:0] d, input bit se,
                            input int nb, input int hold, output int d_start, output int d_stop);
      int s0, p0, w;
      s0 = start_cnt; p0 = stop_cnt;
      cfg_nack = nb; cfg_hold = hold;
      @(negedge clk);
      reg_addr = a; reg_data = d; stretch_en = se; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      chk(busy == 1'b1, "R8", "busy after accept", int'(busy), 1);
      w = 0;
      while (!done && w < 20000) begin
         @(negedge clk);
         w++;
      end
      chk(done == 1'b1 && busy == 1'b0, "R8", "done pulse with busy low", int'(done), 1);
      @(negedge clk);
      chk(done == 1'b0, "R8", "done lasts one cycle", int'(done), 0);
      d_start = start_cnt - s0;
      d_stop = stop_cnt - p0;
   endtask

   task automatic t_reset();
      chk(scl_oe == 1'b0, "R1", "scl released at reset", int'(scl_oe), 0);
      chk(sda_oe == 1'b0, "R1", "sda released at reset", int'(sda_oe), 0);
      chk(busy == 1'b0, "R1", "busy low at reset", int'(busy), 0);
      chk(done == 1'b0 && nack == 1'b0, "R1", "done/nack low at reset", int'(done | nack), 0);
   endtask

   task automatic t_basic_low();
      int ds, dp;
      run_write(8'h12, 8'hA5, 1'b0, -1, 0, ds, dp);
      chk(nbytes == 3, "R2", "byte count", nbytes, 3);
      chk(rx[0] == 8'hB8, "R2", "device byte", int'(rx[0]), 'hB8);
      chk(rx[1] == 8'h12, "R2", "subaddress byte", int'(rx[1]), 'h12);
      chk(rx[2] == 8'hA5, "R2", "data byte", int'(rx[2]), 'hA5);
      chk(ds == 1 && dp == 1, "R3", "one start and one stop", ds * 10 + dp, 11);
      chk(nack == 1'b0, "R7", "no nack on acked frame", int'(nack), 0);
      chk(t_rise - t_fall >= WAIT_TB, "R4", "low-range settle gap", t_rise - t_fall, WAIT_TB);
      chk(t_rise - t_fall <= WAIT_TB + 2 * Q_TB + 2, "R4", "settle gap upper bound", t_rise - t_fall, WAIT_TB + 2 * Q_TB);
      chk(high_len == 2 * Q_TB, "R10", "scl high phase length", high_len, 2 * Q_TB);
      chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1", "lines released after frame", int'(scl_oe | sda_oe), 0);
   endtask

   task automatic t_boundaries();
      int ds, dp;
      run_write(8'h8F, 8'h3C, 1'b0, -1, 0, ds, dp);
      chk(t_rise - t_fall >= WAIT_TB, "R4", "8Fh waits", t_rise - t_fall, WAIT_TB);
      chk(rx[1] == 8'h8F && rx[2] == 8'h3C, "R2", "8Fh bytes", int'(rx[2]), 'h3C);
      run_write(8'h00, 8'hFF, 1'b0, -1, 0, ds, dp);
      chk(t_rise - t_fall >= WAIT_TB, "R4", "00h waits", t_rise - t_fall, WAIT_TB);
      run_write(8'h90, 8'h01, 1'b0, -1, 0, ds, dp);
      chk(t_rise - t_fall == 2 * Q_TB, "R5", "90h no wait", t_rise - t_fall, 2 * Q_TB);
      chk(rx[1] == 8'h90 && dp == 1, "R5", "90h frame completes", int'(rx[1]), 'h90);
      run_write(8'hFF, 8'h5A, 1'b0, -1, 0, ds, dp);
      chk(t_rise - t_fall == 2 * Q_TB, "R5", "FFh no wait", t_rise - t_fall, 2 * Q_TB);
   endtask

   task automatic t_nack();
      int ds, dp;
      run_write(8'h20, 8'h77, 1'b0, 0, 0, ds, dp);
      chk(nack == 1'b1, "R7", "nack on device byte", int'(nack), 1);
      chk(nbytes == 1, "R7", "bytes after device nack", nbytes, 1);
      chk(dp == 1, "R7", "stop after device nack", dp, 1);
      repeat (10) @(negedge clk);
      chk(nack == 1'b1, "R8", "nack held while idle", int'(nack), 1);
      run_write(8'h10, 8'h44, 1'b0, 2, 0, ds, dp);
      chk(nack == 1'b1 && nbytes == 3, "R7", "nack on data byte", nbytes, 3);
      chk(t_rise - t_fall < WAIT_TB, "R7", "no settle after nack", t_rise - t_fall, 2 * Q_TB);
      run_write(8'h95, 8'h66, 1'b0, -1, 0, ds, dp);
      chk(nack == 1'b0, "R8", "nack cleared by next request", int'(nack), 0);
   endtask

   task automatic t_ignore_busy();
      int s0, p0, w;
      s0 = start_cnt; p0 = stop_cnt;
      cfg_nack = -1; cfg_hold = 0;
      @(negedge clk);
      reg_addr = 8'hC1; reg_data = 8'h2E; stretch_en = 1'b0; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      repeat (30) @(negedge clk);
      reg_addr = 8'h05; reg_data = 8'h99; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      w = 0;
      while (!done && w < 20000) begin
         @(negedge clk);
         w++;
      end
      repeat (60) @(negedge clk);
      chk(rx[1] == 8'hC1 && rx[2] == 8'h2E, "R9", "original bytes kept", int'(rx[1]), 'hC1);
      chk(busy == 1'b0, "R9", "no second frame", int'(busy), 0);
      chk(start_cnt - s0 == 1 && stop_cnt - p0 == 1, "R9", "single frame", start_cnt - s0, 1);
   endtask

   task automatic t_stretch();
      int ds, dp;
      run_write(8'h30, 8'h0F, 1'b1, -1, 0, ds, dp);
      chk(t_rise - t_fall < WAIT_TB, "R6", "fixed wait dropped", t_rise - t_fall, 2 * Q_TB);
      chk(rx[2] == 8'h0F && dp == 1, "R6", "stretched frame data", int'(rx[2]), 'h0F);
      run_write(8'h31, 8'hE2, 1'b1, -1, 60, ds, dp);
      chk(t_rise - t_fall >= 60, "R6", "stop waits for slave release", t_rise - t_fall, 60);
      chk(dp == 1 && rx[2] == 8'hE2, "R6", "stop after held scl", dp, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_basic_low();
      t_boundaries();
      t_nack();
      t_ignore_busy();
      t_stretch();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule